// File: doc/BRIEF.md
# Masked Timer Interrupt Flag Aggregator

This block collects the interrupt sources of one timer into a single CPU-level interrupt flag. There are two kinds of source: the terminal-count (overflow) event and one compare event per channel. Each source has a sticky source flag and a mask bit. A source flag records its event whatever its mask is. The CPU-level flag is raised only by sources whose mask is 1.

Software clears source flags and the CPU-level flag with single-cycle write strobes, and it loads the mask bits with a write strobe. Clearing one source flag can leave other masked-in sources pending. In that case the CPU-level flag is set again, so a pending source is not lost when the interrupt handler clears the CPU-level flag first. An interrupt request pulse is issued on the 0-to-1 edge of the CPU-level flag, and only when both the timer's interrupt enable and the global interrupt enable are 1.

Source vectors use one bit order everywhere: bit 0 is the overflow source, and bit 1+k is compare channel k.

Top module: `tmr_irq_agg`

## Requirements
- R1: An event on a source sets that source's flag on the next clock edge, whatever its mask bit is. The flag stays set until it is cleared.
- R2: A clear strobe on a source bit (`src_clr`, bit 0 = overflow, bit 1+k = channel k) clears that flag on the next edge when no event arrives for it.
- R3: When an event and a clear strobe for the same source arrive in the same cycle, the flag is set after the edge.
- R4: An event whose mask bit is 1 sets `cpu_flag` on the next edge. An event whose mask bit is 0 does not set `cpu_flag`.
- R5: When a clear strobe hits a set source flag while another source flag that is not being cleared is set with its mask at 1, `cpu_flag` is set on the next edge.
- R6: `cpu_flag` holds until `cpu_clr` is strobed. When a set condition from R4 or R5 arrives in the same cycle as `cpu_clr`, the flag stays set.
- R7: `irq_req` is high for exactly the first cycle in which `cpu_flag` is 1 after being 0, provided `timer_ien` and `global_ien` are both 1 in that cycle.
- R8: `irq_req` stays low when either enable is 0, and while `cpu_flag` remains at 1 from one cycle to the next.
- R9: After reset, all source flags, `cpu_flag` and `irq_req` are 0. `irq_mask` reads 1 on bit 0 (overflow) and 0 on every channel bit.
- R10: A cycle with `mask_wr` high loads `mask_wdata` into `irq_mask` on the next edge, using the same bit order as the source flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ovf_evt | input | 1 | Terminal-count event, one cycle |
| ch_evt | input | NUM_CH | Compare events, bit k = channel k |
| src_clr | input | NUM_CH+1 | Source flag clear strobes (bit 0 overflow, bit 1+k channel k) |
| cpu_clr | input | 1 | CPU-level flag clear strobe |
| mask_wr | input | 1 | Mask write strobe |
| mask_wdata | input | NUM_CH+1 | Mask value to load |
| timer_ien | input | 1 | Per-timer interrupt enable |
| global_ien | input | 1 | Global interrupt enable |
| src_flag | output | NUM_CH+1 | Sticky source flags |
| irq_mask | output | NUM_CH+1 | Current mask bits |
| cpu_flag | output | 1 | CPU-level interrupt flag |
| irq_req | output | 1 | Interrupt request pulse |

## Verification
The bench builds the block with its default of two compare channels, which gives three sources. Three sources are enough to show the re-arm rule with one flag, two flags or all flags being cleared. The bench sweeps every combination of mask value, pending flag state, event vector and clear vector (4096 cases). It varies the two enables and the CPU clear strobe across those cases, and it derives the expected flags and request from the requirement equations. Directed sequences then cover reset values, mask loading, a set condition colliding with a CPU clear, and the absence of a request while the flag stays high.

// File: rtl/tmr_irq_pkg.sv
// Package: shared index helpers for the timer interrupt aggregator.
// Assumes source vectors put overflow at bit 0 and channel k at bit 1+k.
package tmr_irq_pkg;

    localparam int unsigned OVF_IDX = 0;

    // Map a compare channel number onto its source vector position.
    function automatic int unsigned ch_idx(input int unsigned k);
        return k + 1;
    endfunction

endpackage

// File: rtl/tmr_src_flag.sv
// Module: one interrupt source slot, made of a sticky source flag and its mask bit.
// Assumes event and clear are single-cycle strobes. When both arrive together,
// the event takes priority.
module tmr_src_flag #(
    parameter logic RST_MASK = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic evt,
    input  logic clr,
    input  logic mask_wr,
    input  logic mask_wd,
    output logic flag,
    output logic mask
);

    // Sticky flag: a new event wins over a software clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag <= 1'b0;
        else
            flag <= evt | (flag & ~clr);
    end

    // Mask bit: loaded by the write strobe, reset value set per source.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask <= RST_MASK;
        else if (mask_wr)
            mask <= mask_wd;
    end

endmodule

// File: rtl/tmr_cpu_flag.sv
// Module: CPU-level interrupt flag.
// The flag is set by a masked-in event, or by the re-arm case: a set source
// flag is cleared while another masked-in flag that is not being cleared is
// still pending. Assumes the flag and mask inputs are this cycle's register values.
module tmr_cpu_flag #(
    parameter int unsigned NUM_SRC = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] evt,
    input  logic [NUM_SRC-1:0] clr,
    input  logic [NUM_SRC-1:0] src_flag,
    input  logic [NUM_SRC-1:0] mask,
    input  logic               cpu_clr,
    output logic               cpu_flag
);

    logic evt_hit;
    logic clr_hit;
    logic still_pend;
    logic set_now;

    // Set conditions: a masked event, or a clear that leaves masked work pending.
    always_comb begin
        evt_hit    = |(evt & mask);
        clr_hit    = |(clr & src_flag);
        still_pend = |(src_flag & ~clr & mask);
        set_now    = evt_hit | (clr_hit & still_pend);
    end

    // CPU flag register: a set condition wins over a software clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cpu_flag <= 1'b0;
        else
            cpu_flag <= set_now | (cpu_flag & ~cpu_clr);
    end

endmodule

// File: rtl/tmr_irq_edge.sv
// Module: produces the request pulse on the rising edge of the CPU-level flag.
// The pulse is gated by the timer enable and the global enable as they stand
// in the pulse cycle. Assumes cpu_flag comes straight from a register.
module tmr_irq_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic cpu_flag,
    input  logic timer_ien,
    input  logic global_ien,
    output logic irq_req
);

    logic flag_d;

    // Previous value of the flag, used for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag_d <= 1'b0;
        else
            flag_d <= cpu_flag;
    end

    // Request: high in the first cycle the flag reads 1, when both enables are on.
    always_comb begin
        irq_req = cpu_flag & ~flag_d & timer_ien & global_ien;
    end

endmodule

// File: rtl/tmr_irq_agg.sv
// Module: top of the timer interrupt aggregator, with one overflow source and
// NUM_CH compare-channel sources. Assumes all strobes are synchronous to clk.
// Reset is synchronous and active low.
module tmr_irq_agg #(
    parameter int unsigned NUM_CH = 2,
    localparam int unsigned NUM_SRC = NUM_CH + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ovf_evt,
    input  logic [NUM_CH-1:0]  ch_evt,
    input  logic [NUM_SRC-1:0] src_clr,
    input  logic               cpu_clr,
    input  logic               mask_wr,
    input  logic [NUM_SRC-1:0] mask_wdata,
    input  logic               timer_ien,
    input  logic               global_ien,
    output logic [NUM_SRC-1:0] src_flag,
    output logic [NUM_SRC-1:0] irq_mask,
    output logic               cpu_flag,
    output logic               irq_req
);

    import tmr_irq_pkg::*;

    logic [NUM_SRC-1:0] evt_vec;

    // Gather the events into source order.
    always_comb begin
        evt_vec          = '0;
        evt_vec[OVF_IDX] = ovf_evt;
        for (int k = 0; k < NUM_CH; k++)
            evt_vec[ch_idx(k)] = ch_evt[k];
    end

    // One flag and mask slot per source; only overflow resets enabled.
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        tmr_src_flag #(
            .RST_MASK((i == OVF_IDX) ? 1'b1 : 1'b0)
        ) u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .evt     (evt_vec[i]),
            .clr     (src_clr[i]),
            .mask_wr (mask_wr),
            .mask_wd (mask_wdata[i]),
            .flag    (src_flag[i]),
            .mask    (irq_mask[i])
        );
    end

    tmr_cpu_flag #(
        .NUM_SRC(NUM_SRC)
    ) u_cpu (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt      (evt_vec),
        .clr      (src_clr),
        .src_flag (src_flag),
        .mask     (irq_mask),
        .cpu_clr  (cpu_clr),
        .cpu_flag (cpu_flag)
    );

    tmr_irq_edge u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .cpu_flag   (cpu_flag),
        .timer_ien  (timer_ien),
        .global_ien (global_ien),
        .irq_req    (irq_req)
    );

endmodule

// File: rtl/tmr_irq_agg_chk.sv
// Checker: temporal properties of the aggregator, checked at its ports.
// Attached to every instance of the top module through the bind below.
module tmr_irq_agg_chk #(
    parameter int unsigned NUM_CH = 2,
    localparam int unsigned NUM_SRC = NUM_CH + 1
) (
    input logic               clk,
    input logic               rst_n,
    input logic               ovf_evt,
    input logic [NUM_CH-1:0]  ch_evt,
    input logic [NUM_SRC-1:0] src_clr,
    input logic               cpu_clr,
    input logic               timer_ien,
    input logic               global_ien,
    input logic [NUM_SRC-1:0] src_flag,
    input logic [NUM_SRC-1:0] irq_mask,
    input logic               cpu_flag,
    input logic               irq_req
);

    logic [NUM_SRC-1:0] evt_all;
    assign evt_all = {ch_evt, ovf_evt};

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
        a_r1_evt_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
            evt_all[i] |=> src_flag[i]);
        a_r2_clr_drops_flag: assert property (@(posedge clk) disable iff (!rst_n)
            (src_clr[i] && !evt_all[i]) |=> !src_flag[i]);
    end

    a_r4_masked_evt_sets_cpu: assert property (@(posedge clk) disable iff (!rst_n)
        (|(evt_all & irq_mask)) |=> cpu_flag);

    a_r5_rearm_on_clear: assert property (@(posedge clk) disable iff (!rst_n)
        ((|(src_clr & src_flag)) && (|(src_flag & ~src_clr & irq_mask))) |=> cpu_flag);

    a_r6_cpu_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_flag && !cpu_clr) |=> cpu_flag);

    a_r7_req_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (cpu_flag && !$past(cpu_flag) && timer_ien && global_ien));

    a_r7_req_single: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |=> !irq_req);

endmodule

bind tmr_irq_agg tmr_irq_agg_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ovf_evt    (ovf_evt),
    .ch_evt     (ch_evt),
    .src_clr    (src_clr),
    .cpu_clr    (cpu_clr),
    .timer_ien  (timer_ien),
    .global_ien (global_ien),
    .src_flag   (src_flag),
    .irq_mask   (irq_mask),
    .cpu_flag   (cpu_flag),
    .irq_req    (irq_req)
);

// File: tb/tb_tmr_irq_agg.sv
// Bench: exhaustive sweep over three sources plus directed sequences.
module tb_tmr_irq_agg;

    localparam int unsigned NUM_CH  = 2;
    localparam int unsigned NUM_SRC = NUM_CH + 1;

    logic               clk = 1'b0;
    logic               rst_n;
    logic               ovf_evt;
    logic [NUM_CH-1:0]  ch_evt;
    logic [NUM_SRC-1:0] src_clr;
    logic               cpu_clr;
    logic               mask_wr;
    logic [NUM_SRC-1:0] mask_wdata;
    logic               timer_ien;
    logic               global_ien;
    logic [NUM_SRC-1:0] src_flag;
    logic [NUM_SRC-1:0] irq_mask;
    logic               cpu_flag;
    logic               irq_req;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    tmr_irq_agg #(.NUM_CH(NUM_CH)) dut (
        .clk(clk), .rst_n(rst_n), .ovf_evt(ovf_evt), .ch_evt(ch_evt),
        .src_clr(src_clr), .cpu_clr(cpu_clr), .mask_wr(mask_wr),
        .mask_wdata(mask_wdata), .timer_ien(timer_ien), .global_ien(global_ien),
        .src_flag(src_flag), .irq_mask(irq_mask), .cpu_flag(cpu_flag),
        .irq_req(irq_req)
    );

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        ovf_evt = 1'b0; ch_evt = '0; src_clr = '0; cpu_clr = 1'b0;
        mask_wr = 1'b0; mask_wdata = '0;
    endtask

    task automatic set_evt(input logic [NUM_SRC-1:0] v);
        ovf_evt = v[0];
        ch_evt  = v[NUM_SRC-1:1];
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 190000 && !done) begin
                n_fail++;
                $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
                $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
                $finish;
            end
        end
    end

    initial begin
        logic [2:0] m, f, e, c;
        logic [1:0] en;
        logic       cc;
        logic [2:0] exp_f;
        logic       exp_cpu;

        idle();
        timer_ien = 1'b1; global_ien = 1'b1;
        rst_n = 1'b0;
        @(negedge clk);
        step();
        rst_n = 1'b1;

        // R9: reset values
        check("R9 src_flag", int'(src_flag), 0);
        check("R9 cpu_flag", int'(cpu_flag), 0);
        check("R9 irq_req",  int'(irq_req), 0);
        check("R9 irq_mask", int'(irq_mask), 1);

        // R10: mask load
        mask_wr = 1'b1; mask_wdata = 3'b110;
        step();
        idle();
        check("R10 irq_mask", int'(irq_mask), 6);

        // R4/R6/R7/R8 directed sequence with all masks on
        mask_wr = 1'b1; mask_wdata = 3'b111;
        step();
        idle();
        ovf_evt = 1'b1;
        step();
        idle();
        check("R4 cpu set", int'(cpu_flag), 1);
        check("R7 irq rise", int'(irq_req), 1);
        ch_evt = 2'b01;
        step();
        idle();
        check("R8 cpu still 1", int'(cpu_flag), 1);
        check("R8 no irq while high", int'(irq_req), 0);
        cpu_clr = 1'b1; ch_evt = 2'b10;
        step();
        idle();
        check("R6 set beats clear", int'(cpu_flag), 1);
        check("R8 no irq no edge", int'(irq_req), 0);
        cpu_clr = 1'b1;
        step();
        idle();
        check("R6 cpu_clr clears", int'(cpu_flag), 0);
        check("R1 flags sticky", int'(src_flag), 7);

        // Exhaustive sweep: mask, pending flags, events, clears
        for (int idx = 0; idx < 4096; idx++) begin
            m  = idx[2:0];
            f  = idx[5:3];
            e  = idx[8:6];
            c  = idx[11:9];
            en = idx[1:0] ^ idx[4:3] ^ idx[7:6];
            cc = idx[3] ^ idx[9];

            rst_n = 1'b0; idle();
            step();
            rst_n = 1'b1;
            timer_ien = en[0]; global_ien = en[1];
            mask_wr = 1'b1; mask_wdata = m;
            step();
            idle();
            set_evt(f);
            step();
            idle();
            cpu_clr = 1'b1;
            step();
            idle();

            set_evt(e); src_clr = c; cpu_clr = cc;
            step();
            exp_f   = e | (f & ~c);
            exp_cpu = (|(e & m)) || ((|(c & f)) && (|(f & ~c & m)));
            check("R1/R2/R3 src_flag", int'(src_flag), int'(exp_f));
            check("R4/R5 cpu_flag", int'(cpu_flag), int'(exp_cpu));
            check("R7/R8 irq_req", int'(irq_req), int'(exp_cpu && en == 2'b11));
            idle();
            step();
            check("R7 irq one cycle", int'(irq_req), 0);
            check("R6 cpu holds", int'(cpu_flag), int'(exp_cpu));
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule